// File: doc/BRIEF.md
# I2C Slave Address Front End

This block is the receive side of an I2C slave, up to the end of the address phase. The raw SCL and SDA pins pass through a two-stage synchronizer. They then pass through a debounce filter whose length software selects. The filtered lines feed a START/STOP detector. After each START the block shifts in one byte, most significant bit first. It compares the upper seven bits of that byte with a programmable 7-bit address.

On a match the block raises a select flag and latches the eighth bit as the transfer direction. It then pulls SDA low for the ninth SCL clock to acknowledge. On a mismatch it leaves SDA alone and ignores the bus until the next START.

Software reaches two registers through a simple write port with combinational read-back. One register holds the address byte and the other holds the debounce field. A 3-bit mode input turns the block on only for one code, the I2C slave mode. Data bytes after the address, clock stretching and bus time-outs belong to other blocks.

Top module: `i2c_addr_front`

## Requirements
- R1: The address register is 8 bits and resets to 0x00. It is written when `reg_wr_i`=1 and `reg_sel_i`=0. With `reg_sel_i`=0, `reg_rdata_o` returns all 8 bits, including bit 0.
- R2: Matching compares the first seven received bits (MSB first) with address register bits 7..1. Bit 0 of the address register has no effect on matching.
- R3: The debounce field is bits 1..0 of the control register. It is written when `reg_sel_i`=1, resets to 00, and reads back as {6'b0, field}. The codes mean: 00 = no filtering, 01 = a new level must hold 2 consecutive system clocks, 10 or 11 = it must hold 4 consecutive system clocks. A shorter pulse on a pin has no effect.
- R4: `start_o` pulses for one clock when filtered SDA falls while filtered SCL stays high. `stop_o` pulses for one clock when filtered SDA rises while SCL stays high. The two never pulse together.
- R5: On an address match, `sel_o` becomes 1 and `rw_o` takes the eighth received bit. `sda_oe_o` (1 = pull SDA low) is high from the SCL fall after the eighth bit until the SCL fall after the ninth bit, so it covers the whole ninth SCL high phase.
- R6: On a mismatch, `sda_oe_o` stays 0 and `sel_o` stays 0. Further bytes are ignored until a new START, and that START begins a fresh address comparison.
- R7: A START or a STOP clears `sel_o` and releases `sda_oe_o` on the next clock.
- R8: When `mode_i` is not 3'b110, the block gives no START/STOP pulse, `sel_o` is 0 and `sda_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Peripheral mode; 3'b110 enables this block |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0 = address register, 1 = control register |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read-back of the selected register |
| scl_i | input | 1 | Raw SCL pin level |
| sda_i | input | 1 | Raw SDA pin level |
| sda_oe_o | output | 1 | 1 = drive SDA low (acknowledge) |
| start_o | output | 1 | One-clock START pulse |
| stop_o | output | 1 | One-clock STOP pulse |
| sel_o | output | 1 | Slave addressed |
| rw_o | output | 1 | Direction bit of the matched address byte |

## Verification
The hardest case to reach from the ports is a spike on SDA while SCL idles high whose width sits right at the debounce threshold. For example, a 1-clock spike must be rejected with the 2-clock setting, and a 3-clock spike must pass with the 2-clock setting but be rejected with the 4-clock setting. The bench reaches these cases by driving SDA from the falling clock edge for an exact number of clocks. It then counts START and STOP pulses for each debounce code, including the 11 code.

// File: rtl/i2c_afe_pkg.sv
package i2c_afe_pkg;
    localparam logic [2:0] MODE_I2C_SLAVE = 3'b110;
    localparam int         DEB_SHORT      = 2;
    localparam int         DEB_LONG       = 4;
    localparam int         BYTE_BITS      = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_WAIT,
        ST_ACK,
        ST_SEL,
        ST_IGNORE
    } addr_st_e;
endpackage

// File: rtl/i2c_afe_filt.sv
module i2c_afe_filt #(
    parameter int SYNC_STAGES = 2,
    parameter int MAX_LEN     = 4,
    localparam int CNT_W      = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raw_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             filt_o
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   filt;
        logic [CNT_W-1:0]       cnt;
    } filt_t;

    filt_t st_d, st_q;
    logic  sample;

    assign sample = st_q.sync[SYNC_STAGES-1];

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], raw_i};
        if (len_i == '0) begin
            st_d.filt = sample;
            st_d.cnt  = '0;
        end else if (sample != st_q.filt) begin
            if ((st_q.cnt + CNT_W'(1)) >= len_i) begin
                st_d.filt = sample;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sync <= '1;
            st_q.filt <= 1'b1;
            st_q.cnt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign filt_o = st_q.filt;
endmodule

// File: rtl/i2c_afe_cond.sv
module i2c_afe_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic scl_i,
    input  logic sda_i,
    output logic start_o,
    output logic stop_o,
    output logic scl_rise_o,
    output logic scl_fall_o
);
    typedef struct packed {
        logic scl;
        logic sda;
    } line_t;

    line_t prev_d, prev_q;

    always_comb begin
        prev_d.scl = scl_i;
        prev_d.sda = sda_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '1;
        end else begin
            prev_q <= prev_d;
        end
    end

    assign start_o    = en_i & prev_q.scl & scl_i & prev_q.sda & ~sda_i;
    assign stop_o     = en_i & prev_q.scl & scl_i & ~prev_q.sda & sda_i;
    assign scl_rise_o = en_i & ~prev_q.scl & scl_i;
    assign scl_fall_o = en_i & prev_q.scl & ~scl_i;
endmodule

// File: rtl/i2c_afe_match.sv
module i2c_afe_match
    import i2c_afe_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       start_i,
    input  logic       stop_i,
    input  logic       rise_i,
    input  logic       fall_i,
    input  logic       sda_i,
    input  logic [6:0] addr_i,
    output logic       sel_o,
    output logic       rw_o,
    output logic       oe_o
);
    localparam int BIT_W = $clog2(BYTE_BITS + 1);

    typedef struct packed {
        addr_st_e             st;
        logic [BYTE_BITS-1:0] shift;
        logic [BIT_W-1:0]     bits;
        logic                 sel;
        logic                 rw;
        logic                 oe;
    } match_t;

    match_t m_d, m_q;
    logic [BYTE_BITS-1:0] shift_nxt;

    assign shift_nxt = {m_q.shift[BYTE_BITS-2:0], sda_i};

    always_comb begin
        m_d = m_q;
        if (!en_i) begin
            m_d.st  = ST_IDLE;
            m_d.sel = 1'b0;
            m_d.oe  = 1'b0;
        end else if (start_i) begin
            m_d.st    = ST_ADDR;
            m_d.bits  = '0;
            m_d.shift = '0;
            m_d.sel   = 1'b0;
            m_d.oe    = 1'b0;
        end else if (stop_i) begin
            m_d.st  = ST_IDLE;
            m_d.sel = 1'b0;
            m_d.oe  = 1'b0;
        end else begin
            unique case (m_q.st)
                ST_ADDR: begin
                    if (rise_i) begin
                        m_d.shift = shift_nxt;
                        m_d.bits  = m_q.bits + BIT_W'(1);
                        if (m_q.bits == BIT_W'(BYTE_BITS - 1)) begin
                            if (shift_nxt[BYTE_BITS-1:1] == addr_i) begin
                                m_d.st  = ST_ACK_WAIT;
                                m_d.sel = 1'b1;
                                m_d.rw  = shift_nxt[0];
                            end else begin
                                m_d.st = ST_IGNORE;
                            end
                        end
                    end
                end
                ST_ACK_WAIT: begin
                    if (fall_i) begin
                        m_d.oe = 1'b1;
                        m_d.st = ST_ACK;
                    end
                end
                ST_ACK: begin
                    if (fall_i) begin
                        m_d.oe = 1'b0;
                        m_d.st = ST_SEL;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q.st    <= ST_IDLE;
            m_q.shift <= '0;
            m_q.bits  <= '0;
            m_q.sel   <= 1'b0;
            m_q.rw    <= 1'b0;
            m_q.oe    <= 1'b0;
        end else begin
            m_q <= m_d;
        end
    end

    assign sel_o = m_q.sel;
    assign rw_o  = m_q.rw;
    assign oe_o  = m_q.oe;
endmodule

// File: rtl/i2c_addr_front.sv
module i2c_addr_front
    import i2c_afe_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode_i,
    input  logic       reg_wr_i,
    input  logic       reg_sel_i,
    input  logic [7:0] reg_wdata_i,
    output logic [7:0] reg_rdata_o,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    output logic       start_o,
    output logic       stop_o,
    output logic       sel_o,
    output logic       rw_o
);
    localparam int CNT_W = $clog2(DEB_LONG + 1);

    typedef struct packed {
        logic [7:0] addr;
        logic [1:0] deb;
    } regs_t;

    regs_t regs_d, regs_q;
    logic              en;
    logic [CNT_W-1:0]  len;
    logic [1:0]        raw_lines;
    logic [1:0]        filt_lines;
    logic              rise, fall;

    always_comb begin
        regs_d = regs_q;
        if (reg_wr_i) begin
            if (reg_sel_i) regs_d.deb  = reg_wdata_i[1:0];
            else           regs_d.addr = reg_wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign reg_rdata_o = reg_sel_i ? {6'b0, regs_q.deb} : regs_q.addr;

    assign en = (mode_i == MODE_I2C_SLAVE);

    always_comb begin
        if (!en || regs_q.deb == 2'b00) len = '0;
        else if (regs_q.deb == 2'b01)   len = CNT_W'(DEB_SHORT);
        else                            len = CNT_W'(DEB_LONG);
    end

    assign raw_lines = {scl_i, sda_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        i2c_afe_filt #(
            .SYNC_STAGES(SYNC_STAGES),
            .MAX_LEN    (DEB_LONG)
        ) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw_i (raw_lines[g]),
            .len_i (len),
            .filt_o(filt_lines[g])
        );
    end

    i2c_afe_cond u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en),
        .scl_i     (filt_lines[1]),
        .sda_i     (filt_lines[0]),
        .start_o   (start_o),
        .stop_o    (stop_o),
        .scl_rise_o(rise),
        .scl_fall_o(fall)
    );

    i2c_afe_match u_match (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (en),
        .start_i(start_o),
        .stop_i (stop_o),
        .rise_i (rise),
        .fall_i (fall),
        .sda_i  (filt_lines[0]),
        .addr_i (regs_q.addr[7:1]),
        .sel_o  (sel_o),
        .rw_o   (rw_o),
        .oe_o   (sda_oe_o)
    );
endmodule

// File: rtl/i2c_afe_chk.sv
module i2c_afe_chk
    import i2c_afe_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] mode_i,
    input logic       start_o,
    input logic       stop_o,
    input logic       sel_o,
    input logic       sda_oe_o
);
    assert_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_o && stop_o));

    assert_oe_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe_o |-> sel_o);

    assert_start_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> (!sel_o && !sda_oe_o));

    assert_stop_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |=> (!sel_o && !sda_oe_o));

    assert_mode_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != MODE_I2C_SLAVE) |=> (!sel_o && !sda_oe_o));

    assert_mode_nopulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != MODE_I2C_SLAVE) |-> (!start_o && !stop_o));
endmodule

bind i2c_addr_front i2c_afe_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_i  (mode_i),
    .start_o (start_o),
    .stop_o  (stop_o),
    .sel_o   (sel_o),
    .sda_oe_o(sda_oe_o)
);

// File: tb/i2c_addr_front_bench.sv
module i2c_addr_front_bench;
    localparam time CLK_PERIOD = 10ns;
    localparam int  QTR = 8;
    localparam int  HALF = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode = 3'b110;
    logic       reg_wr = 1'b0;
    logic       reg_sel = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_bus;
    logic       sda_oe, start_p, stop_p, sel, rw;
    int         n_chk = 0;
    int         n_fail = 0;
    int         start_cnt = 0;
    int         stop_cnt = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    i2c_addr_front u_i2c_addr_front (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode),
        .reg_wr_i   (reg_wr),
        .reg_sel_i  (reg_sel),
        .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata),
        .scl_i      (scl_m),
        .sda_i      (sda_bus),
        .sda_oe_o   (sda_oe),
        .start_o    (start_p),
        .stop_o     (stop_p),
        .sel_o      (sel),
        .rw_o       (rw)
    );

    always @(posedge clk) begin
        if (start_p) start_cnt <= start_cnt + 1;
        if (stop_p)  stop_cnt  <= stop_cnt + 1;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input logic s, input logic [7:0] v);
        @(negedge clk);
        reg_sel = s; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic s, output logic [7:0] v);
        @(negedge clk);
        reg_sel = s;
        #1 v = reg_rdata;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_clk(QTR);
        scl_m = 1'b1; wait_clk(HALF);
        sda_m = 1'b0; wait_clk(HALF);
        scl_m = 1'b0; wait_clk(QTR);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_clk(QTR);
        scl_m = 1'b1; wait_clk(HALF);
        sda_m = 1'b1; wait_clk(HALF);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_clk(QTR);
            scl_m = 1'b1; wait_clk(HALF);
            scl_m = 1'b0; wait_clk(QTR);
        end
        sda_m = 1'b1; wait_clk(QTR);
        scl_m = 1'b1; wait_clk(2);
        ack = sda_oe;
        wait_clk(HALF / 2 - 2);
        ack = ack & sda_oe & ~sda_bus;
        wait_clk(HALF / 2);
        scl_m = 1'b0; wait_clk(QTR);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        reg_read(1'b0, v); chk("R1 addr reset", v, 0);
        reg_read(1'b1, v); chk("R3 deb reset", v, 0);
        chk("R5 sel reset", sel, 0);
        chk("R5 oe reset", sda_oe, 0);
    endtask

    task automatic t_match();
        logic ack;
        reg_write(1'b0, 8'hA4);
        reg_write(1'b1, 8'h01);
        bus_start();
        send_byte(8'hA5, ack);
        chk("R5 ack on match", ack, 1);
        chk("R5 sel on match", sel, 1);
        chk("R5 rw=1", rw, 1);
        wait_clk(4);
        chk("R5 oe released after ninth", sda_oe, 0);
        bus_stop();
        wait_clk(4);
        chk("R7 stop clears sel", sel, 0);
    endtask

    task automatic t_bit0_mismatch();
        logic ack;
        logic [7:0] v;
        reg_write(1'b0, 8'hA5);
        reg_read(1'b0, v); chk("R1 bit0 readback", v, 8'hA5);
        bus_start();
        send_byte(8'hA4, ack);
        chk("R2 bit0 ignored ack", ack, 1);
        chk("R2 rw=0", rw, 0);
        bus_start();
        send_byte(8'h24, ack);
        chk("R6 msb mismatch no ack", ack, 0);
        chk("R7 restart cleared sel", sel, 0);
        send_byte(8'hA5, ack);
        chk("R6 ignored until start ack", ack, 0);
        chk("R6 ignored until start sel", sel, 0);
        bus_start();
        send_byte(8'hA6, ack);
        chk("R6 lsb-addr mismatch", ack, 0);
        bus_start();
        send_byte(8'hA5, ack);
        chk("R6 new start re-matches", ack, 1);
        chk("R6 sel after re-match", sel, 1);
        bus_stop();
        wait_clk(4);
    endtask

    task automatic t_mode();
        logic ack;
        int s0;
        mode = 3'b000;
        wait_clk(4);
        s0 = start_cnt;
        bus_start();
        send_byte(8'hA5, ack);
        chk("R8 no ack when off", ack, 0);
        chk("R8 no sel when off", sel, 0);
        chk("R8 no start when off", start_cnt, s0);
        bus_stop();
        mode = 3'b110;
        wait_clk(8);
    endtask

    task automatic glitch(input logic [1:0] deb, input int width,
                          input int exp_pulses, input string tag);
        int s0, p0;
        reg_write(1'b1, {6'b0, deb});
        wait_clk(8);
        s0 = start_cnt; p0 = stop_cnt;
        sda_m = 1'b0;
        wait_clk(width);
        sda_m = 1'b1;
        wait_clk(12);
        chk({tag, " start count"}, start_cnt - s0, exp_pulses);
        chk({tag, " stop count"}, stop_cnt - p0, exp_pulses);
    endtask

    task automatic t_debounce();
        logic [7:0] v;
        reg_write(1'b1, 8'hFF);
        reg_read(1'b1, v); chk("R3 deb readback", v, 3);
        glitch(2'b00, 1, 1, "R3/R4 none 1clk");
        glitch(2'b01, 1, 0, "R3 two 1clk");
        glitch(2'b01, 3, 1, "R3 two 3clk");
        glitch(2'b11, 3, 0, "R3 four(11) 3clk");
        glitch(2'b10, 5, 1, "R3 four(10) 5clk");
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        t_reset();
        t_match();
        t_bit0_mismatch();
        t_mode();
        t_debounce();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule